// File: doc/BRIEF.md
# Horizontal Drive Soft-Start Controller

This block produces the horizontal drive pulse of a deflection section from a line-rate reference tick. The pulse begins on the clock after each reference tick and stays high for a programmed number of clock cycles, the on-time. The controller never gates the drive on or off abruptly. When the drive is enabled, the on-time climbs one count at a time, and when it is disabled, the on-time falls the same way. Only after the on-time has reached zero is the output treated as off. A low-power start option brings the drive up to a reduced on-time and keeps it there. Full operation waits until the main supply is reported good and a run command has arrived.

Run and standby commands use a two-bit handshake: a command counts only when both bits change in the same cycle. The single/double line-rate selection is taken over only while the block is in standby. A supervisor watches the returning flyback pulse while the drive is enabled. It raises a status flag when three line periods in a row end without a flyback, and drops the flag as soon as a flyback edge is seen again.

Top module: `hdrive_softstart`

## Requirements
- R1: After reset the block is in standby: `drive_o` stays low for whole lines, `nofb_o` is 0 and `mode_o` is 0 (0 = single line rate, 1 = double line rate).
- R2: `drive_o` goes high in the clock cycle after a `line_tick` and stays high for exactly the current on-time in clock cycles. While ramping, the on-time changes by one count at a `line_tick` once every `ramp_lines` ticks, and a `ramp_lines` of 0 behaves as 1.
- R3: A run command is a cycle in which both `stby_bits` differ from their values in the previous cycle. From standby, with `supply_ok` high, it starts a ramp from 0 up to `NOM_ON`, after which the on-time is held.
- R4: A cycle in which exactly one `stby_bits` bit changes is ignored: the on-time and the run/standby state do not change.
- R5: A second command (both bits changing) ramps the on-time down one count per `ramp_lines` ticks to 0. The block then enters standby, and `drive_o` stays low.
- R6: `mode_o` takes the value of `mode_req` only while in standby. Outside standby it holds its value.
- R7: `nofb_o` is set at the third consecutive `line_tick` that ends a line without a rising edge on `flyback_i`, counted while the drive is enabled. It clears in the cycle after a flyback rising edge, and it is 0 in standby.
- R8: In standby with `lp_start` high and no run command pending with `supply_ok`, the on-time ramps up to LP_ON = floor(NOM_ON*3/10) and is held there.
- R9: In low-power start, a run command alone keeps the on-time at LP_ON while `supply_ok` is low. Once `supply_ok` is high as well, the on-time ramps on to `NOM_ON`.
- R10: In low-power start without a run command, dropping `lp_start` ramps the on-time down to 0 and returns the block to standby.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_tick | input | 1 | One-cycle line reference tick |
| flyback_i | input | 1 | Returning flyback pulse, synchronous |
| stby_bits | input | 2 | Run/standby handshake bits |
| mode_req | input | 1 | Requested line-rate mode (0 single, 1 double) |
| lp_start | input | 1 | Low-power start-up requested |
| supply_ok | input | 1 | Main supply ready |
| ramp_lines | input | RLW | Lines per on-time step (0 treated as 1) |
| drive_o | output | 1 | Horizontal drive pulse |
| nofb_o | output | 1 | Missing-flyback status |
| mode_o | output | 1 | Current line-rate mode |

## Verification
Every internal state of this block shows up within one line as the width of the drive pulse. The bench therefore logs that width for each line and checks the ramp shape: each step is one count, and each intermediate value is held for exactly `ramp_lines` lines. A corrupted handshake register or state register shows up as a ramp that starts or stops at the wrong moment, or never at all, and this is visible by the next line tick. A wrong miss counter moves the edge of `nofb_o` by a whole line. A mode register that is not locked lets `mode_o` follow `mode_req` in the very next cycle.

// File: rtl/hds_pkg.sv
// Shared types for the horizontal drive soft-start controller.
// Assumes: one clock domain, all inputs already synchronous.
package hds_pkg;

    // Drive sequencing states
    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,  // standby, on-time is zero
        ST_LP_UP   = 3'd1,  // low-power start, climbing to the reduced on-time
        ST_LP_HOLD = 3'd2,  // low-power start, holding the reduced on-time
        ST_UP      = 3'd3,  // slow start toward nominal
        ST_RUN     = 3'd4,  // nominal on-time
        ST_DOWN    = 3'd5   // slow stop toward zero
    } hds_state_e;

endpackage

// File: rtl/hds_stby_handshake.sv
// Standby handshake decoder.
// Toggles the run request only when every control bit flips in the same
// cycle; a partial flip is ignored but still becomes the new reference.
// Assumes: control bits are synchronous and 0 during reset.
module hds_stby_handshake #(
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] stby_bits,
    output logic          run_req
);

    localparam logic [SW-1:0] ALL_FLIP = '1;

    logic [SW-1:0] prev_q;
    logic          run_q;
    logic          full_flip;

    // Command is valid only when all bits differ from the previous cycle
    assign full_flip = ((stby_bits ^ prev_q) == ALL_FLIP);

    // Track the previous bits and toggle the run request on a full flip
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            run_q  <= 1'b0;
        end else begin
            prev_q <= stby_bits;
            if (full_flip) begin
                run_q <= ~run_q;
            end
        end
    end

    assign run_req = run_q;

    // R4: a single-bit change leaves the run request untouched
    a_r4_partial_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(stby_bits ^ prev_q) == 1) |=> $stable(run_q));

    // R3: a full flip always toggles the run request
    a_r3_full_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(stby_bits ^ prev_q) == SW) |=> (run_q != $past(run_q)));

endmodule

// File: rtl/hds_ramp_fsm.sv
// On-time sequencer: slow start, slow stop, low-power start and the
// standby-only line-rate mode register.
// Assumes: line_tick is a single-cycle pulse; the on-time is only changed
// at a tick so every line carries one consistent pulse width.
module hds_ramp_fsm
    import hds_pkg::*;
#(
    parameter int ONW    = 8,
    parameter int NOM_ON = 200,
    parameter int LP_ON  = 60,
    parameter int RLW    = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           line_tick,
    input  logic           run_req,
    input  logic           lp_start,
    input  logic           supply_ok,
    input  logic [RLW-1:0] ramp_lines,
    input  logic           mode_req,
    output logic [ONW-1:0] on_time,
    output logic           drv_en,
    output logic           mode_o
);

    localparam logic [ONW-1:0] NOM_V = ONW'(NOM_ON);
    localparam logic [ONW-1:0] LP_V  = ONW'(LP_ON);
    localparam logic [RLW:0]   ONE_L = (RLW+1)'(1);

    hds_state_e     st_q, st_d;
    logic [ONW-1:0] on_q;
    logic [RLW-1:0] lcnt_q;
    logic           mode_q;
    logic [RLW:0]   eff_n;
    logic [RLW:0]   lcnt_inc;
    logic           ramping;
    logic           step_due;
    logic           go_run;

    // Lines per step, with zero treated as one
    assign eff_n    = (ramp_lines == '0) ? ONE_L : {1'b0, ramp_lines};
    assign lcnt_inc = {1'b0, lcnt_q} + ONE_L;
    assign ramping  = (st_q == ST_LP_UP) || (st_q == ST_UP) || (st_q == ST_DOWN);
    assign step_due = ramping && line_tick && (lcnt_inc >= eff_n);
    assign go_run   = run_req && supply_ok;

    // Next-state selection for the drive sequence
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_OFF: begin
                if (go_run)        st_d = ST_UP;
                else if (lp_start) st_d = ST_LP_UP;
            end
            ST_LP_UP: begin
                if (go_run)             st_d = ST_UP;
                else if (!lp_start)     st_d = ST_DOWN;
                else if (on_q == LP_V)  st_d = ST_LP_HOLD;
            end
            ST_LP_HOLD: begin
                if (go_run)         st_d = ST_UP;
                else if (!lp_start) st_d = ST_DOWN;
            end
            ST_UP: begin
                if (!run_req)           st_d = ST_DOWN;
                else if (on_q == NOM_V) st_d = ST_RUN;
            end
            ST_RUN: begin
                if (!run_req) st_d = ST_DOWN;
            end
            ST_DOWN: begin
                if (on_q == '0) st_d = ST_OFF;
            end
            default: st_d = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    // Line counter pacing the on-time steps
    always_ff @(posedge clk) begin
        if (!rst_n || !ramping) begin
            lcnt_q <= '0;
        end else if (line_tick) begin
            lcnt_q <= step_due ? '0 : lcnt_q + 1'b1;
        end
    end

    // On-time register: one count per step toward the state's target
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q <= '0;
        end else if (step_due) begin
            case (st_q)
                ST_LP_UP: if (on_q < LP_V)  on_q <= on_q + 1'b1;
                ST_UP:    if (on_q < NOM_V) on_q <= on_q + 1'b1;
                ST_DOWN:  if (on_q != '0)   on_q <= on_q - 1'b1;
                default: ;
            endcase
        end
    end

    // Line-rate mode is taken over only in standby
    always_ff @(posedge clk) begin
        if (!rst_n)              mode_q <= 1'b0;
        else if (st_q == ST_OFF) mode_q <= mode_req;
    end

    assign on_time = on_q;
    assign drv_en  = (st_q != ST_OFF);
    assign mode_o  = mode_q;

    // R2: the on-time never moves by more than one count per cycle
    a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (on_q == $past(on_q)) || (on_q == ONW'($past(on_q) + 1'b1)) ||
        (on_q == ONW'($past(on_q) - 1'b1)));

    // R5: standby is only ever occupied with a zero on-time
    a_r5_standby_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OFF) |-> (on_q == '0));

    // R6: the mode is frozen outside standby
    a_r6_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_OFF) |=> $stable(mode_q));

    // R8: low-power start never exceeds the reduced on-time
    a_r8_lp_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_LP_UP) || (st_q == ST_LP_HOLD)) |-> (on_q <= LP_V));

    // R9: without a good supply the low-power hold is not left for slow start
    a_r9_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_LP_HOLD) && !supply_ok) |=> (st_q != ST_UP));

endmodule

// File: rtl/hds_pulse_gen.sv
// Drive pulse former: counts clock cycles since the last line tick and
// keeps the drive high while that count is below the on-time.
// Assumes: the line period stays longer than the largest on-time.
module hds_pulse_gen #(
    parameter int ONW = 8,
    parameter int PW  = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           line_tick,
    input  logic           en,
    input  logic [ONW-1:0] on_time,
    output logic           drive_o
);

    localparam logic [PW-1:0] POS_MAX = '1;

    logic [PW-1:0] pos_q;

    // Position within the line, saturating so a lost tick stays low
    always_ff @(posedge clk) begin
        if (!rst_n)                pos_q <= POS_MAX;
        else if (line_tick)        pos_q <= '0;
        else if (pos_q != POS_MAX) pos_q <= pos_q + 1'b1;
    end

    assign drive_o = en && ({{(PW-ONW){1'b0}}, on_time} > pos_q);

    // R2: a pulse can only begin in the cycle after a line tick
    a_r2_rise_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_o) |-> $past(line_tick));

endmodule

// File: rtl/hds_flyback_mon.sv
// Flyback supervisor: counts line ticks that end without a flyback edge
// and raises a status flag after a programmable run of such lines.
// Assumes: supervision is meaningful only while the drive is enabled.
module hds_flyback_mon #(
    parameter int MISS_LINES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_tick,
    input  logic flyback_i,
    input  logic enable,
    output logic nofb_o
);

    localparam int             MW  = $clog2(MISS_LINES + 1);
    localparam logic [MW:0]    LIM = (MW+1)'(MISS_LINES);
    localparam logic [MW-1:0]  SAT = MW'(MISS_LINES);

    logic          fb_prev_q;
    logic          seen_q;
    logic [MW-1:0] miss_q;
    logic          nofb_q;
    logic          fb_edge;
    logic          line_missed;

    assign fb_edge     = flyback_i && !fb_prev_q;
    assign line_missed = line_tick && !seen_q && !fb_edge;

    // Edge detector history
    always_ff @(posedge clk) begin
        if (!rst_n) fb_prev_q <= 1'b0;
        else        fb_prev_q <= flyback_i;
    end

    // Per-line flyback flag, consecutive-miss counter and status flag
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            seen_q <= 1'b0;
            miss_q <= '0;
            nofb_q <= 1'b0;
        end else begin
            if (line_tick) begin
                seen_q <= 1'b0;
                if (!line_missed)        miss_q <= '0;
                else if (miss_q != SAT)  miss_q <= miss_q + 1'b1;
            end else if (fb_edge) begin
                seen_q <= 1'b1;
            end
            if (fb_edge) begin
                nofb_q <= 1'b0;
            end else if (line_missed && (({1'b0, miss_q} + 1'b1) >= LIM)) begin
                nofb_q <= 1'b1;
            end
        end
    end

    assign nofb_o = nofb_q;

    // R7: a flyback edge clears the flag on the next cycle
    a_r7_clear_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        fb_edge |=> !nofb_q);

    // R7: the flag can only be raised by a line tick
    a_r7_set_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nofb_q) |-> $past(line_tick));

    // R7: no missing-flyback report while the drive is disabled
    a_r7_quiet_standby: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !nofb_q);

endmodule

// File: rtl/hdrive_softstart.sv
// Horizontal drive soft-start controller, top level.
// Connects the standby handshake, the on-time sequencer, the pulse former
// and the flyback supervisor. Assumes synchronous inputs and a line period
// longer than NOM_ON clock cycles.
module hdrive_softstart #(
    parameter int ONW        = 8,
    parameter int NOM_ON     = 200,
    parameter int RLW        = 8,
    parameter int MISS_LINES = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           line_tick,
    input  logic           flyback_i,
    input  logic [1:0]     stby_bits,
    input  logic           mode_req,
    input  logic           lp_start,
    input  logic           supply_ok,
    input  logic [RLW-1:0] ramp_lines,
    output logic           drive_o,
    output logic           nofb_o,
    output logic           mode_o
);

    localparam int LP_ON = (NOM_ON * 3) / 10;
    localparam int PW    = ONW + 2;

    logic           run_req;
    logic [ONW-1:0] on_time;
    logic           drv_en;

    hds_stby_handshake #(.SW(2)) u_hs (
        .clk       (clk),
        .rst_n     (rst_n),
        .stby_bits (stby_bits),
        .run_req   (run_req)
    );

    hds_ramp_fsm #(
        .ONW    (ONW),
        .NOM_ON (NOM_ON),
        .LP_ON  (LP_ON),
        .RLW    (RLW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_tick  (line_tick),
        .run_req    (run_req),
        .lp_start   (lp_start),
        .supply_ok  (supply_ok),
        .ramp_lines (ramp_lines),
        .mode_req   (mode_req),
        .on_time    (on_time),
        .drv_en     (drv_en),
        .mode_o     (mode_o)
    );

    hds_pulse_gen #(.ONW(ONW), .PW(PW)) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_tick (line_tick),
        .en        (drv_en),
        .on_time   (on_time),
        .drive_o   (drive_o)
    );

    hds_flyback_mon #(.MISS_LINES(MISS_LINES)) u_fbmon (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_tick (line_tick),
        .flyback_i (flyback_i),
        .enable    (drv_en),
        .nofb_o    (nofb_o)
    );

endmodule

// File: tb/tb_hdrive_softstart.sv
// Directed bench for the horizontal drive soft-start controller.
module tb_hdrive_softstart;

    localparam int NOM  = 24;
    localparam int LPV  = (NOM * 3) / 10;   // 7
    localparam int LINE = 40;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       line_tick;
    logic       flyback_i;
    logic [1:0] stby_bits;
    logic       mode_req;
    logic       lp_start;
    logic       supply_ok;
    logic [7:0] ramp_lines;
    logic       drive_o;
    logic       nofb_o;
    logic       mode_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // line generator / width monitor state
    bit line_en = 1'b1;
    bit fb_en   = 1'b1;
    int lcount  = 0;
    int cur_w   = 0;
    int last_w  = 0;
    int lines_seen = 0;
    bit rec_on  = 1'b0;
    int w_n     = 0;
    int w_log [0:127];

    always #4 clk = ~clk;

    hdrive_softstart #(.NOM_ON(NOM)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_tick  (line_tick),
        .flyback_i  (flyback_i),
        .stby_bits  (stby_bits),
        .mode_req   (mode_req),
        .lp_start   (lp_start),
        .supply_ok  (supply_ok),
        .ramp_lines (ramp_lines),
        .drive_o    (drive_o),
        .nofb_o     (nofb_o),
        .mode_o     (mode_o)
    );

    // Line tick / flyback generator and per-line pulse width monitor
    initial begin
        line_tick = 1'b0;
        flyback_i = 1'b0;
        forever begin
            @(negedge clk);
            if (line_tick) begin
                last_w = cur_w;
                cur_w  = drive_o ? 1 : 0;
                lines_seen++;
                if (rec_on && w_n < 128) begin
                    w_log[w_n] = last_w;
                    w_n++;
                end
            end else begin
                cur_w += drive_o ? 1 : 0;
            end
            lcount    = (lcount == LINE - 1) ? 0 : lcount + 1;
            line_tick = line_en && (lcount == 0);
            flyback_i = fb_en && (lcount >= 30) && (lcount < 33);
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_lines(input int n);
        int target;
        target = lines_seen + n;
        while (lines_seen < target) step();
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int cnt_eq(input int v);
        int c = 0;
        for (int i = 0; i < w_n; i++) if (w_log[i] == v) c++;
        return c;
    endfunction

    function automatic int max_jump();
        int m = 0;
        for (int i = 1; i < w_n; i++) begin
            int d = w_log[i] - w_log[i-1];
            if (d < 0) d = -d;
            if (d > m) m = d;
        end
        return m;
    endfunction

    // R1: standby after reset
    task automatic t_reset();
        wait_lines(2);
        chk("R1 drive width", last_w, 0);
        chk("R1 nofb", int'(nofb_o), 0);
        chk("R1 mode", int'(mode_o), 0);
    endtask

    // R2/R3: slow start with two lines per step
    task automatic t_slow_start();
        ramp_lines = 8'd2;
        w_n = 0; rec_on = 1'b1;
        stby_bits = 2'b11;
        wait_lines(60);
        rec_on = 1'b0;
        chk("R3 final width", w_log[w_n-1], NOM);
        chk("R2 hold of width 10", cnt_eq(10), 2);
        chk("R2 hold of width 23", cnt_eq(23), 2);
        chk("R2 max step", max_jump(), 1);
    endtask

    // R4: single-bit changes ignored
    task automatic t_partial();
        stby_bits = 2'b10;
        wait_lines(6);
        chk("R4 width after one-bit change", last_w, NOM);
        stby_bits = 2'b00;
        wait_lines(6);
        chk("R4 width after second one-bit change", last_w, NOM);
        stby_bits = 2'b10;
        step();
    endtask

    // R6: mode request while running is not taken
    task automatic t_mode_locked();
        mode_req = 1'b1;
        step(); step();
        chk("R6 mode held while running", int'(mode_o), 0);
    endtask

    // R7: missing flyback detection and clearing
    task automatic t_flyback();
        wait_lines(1);
        fb_en = 1'b0;
        wait_lines(2);
        chk("R7 nofb after two missed lines", int'(nofb_o), 0);
        wait_lines(1);
        chk("R7 nofb after three missed lines", int'(nofb_o), 1);
        fb_en = 1'b1;
        wait_lines(1);
        chk("R7 nofb cleared by flyback", int'(nofb_o), 0);
    endtask

    // R5/R6/R7: slow stop with three lines per step
    task automatic t_slow_stop();
        ramp_lines = 8'd3;
        w_n = 0; rec_on = 1'b1;
        stby_bits = 2'b01;
        wait_lines(90);
        rec_on = 1'b0;
        chk("R5 hold of width 10", cnt_eq(10), 3);
        chk("R5 width in standby", last_w, 0);
        chk("R5 max step", max_jump(), 1);
        chk("R6 mode taken in standby", int'(mode_o), 1);
        chk("R7 nofb in standby", int'(nofb_o), 0);
    endtask

    // R8/R9/R2: low-power start then hand-over to full start
    task automatic t_low_power();
        ramp_lines = 8'd0;
        supply_ok  = 1'b0;
        lp_start   = 1'b1;
        w_n = 0; rec_on = 1'b1;
        wait_lines(20);
        rec_on = 1'b0;
        chk("R8 reduced width", last_w, LPV);
        chk("R2 zero means one line per step", cnt_eq(3), 1);
        stby_bits = 2'b10;
        wait_lines(10);
        chk("R9 held without supply", last_w, LPV);
        supply_ok = 1'b1;
        wait_lines(30);
        chk("R9 nominal after supply", last_w, NOM);
        lp_start  = 1'b0;
        stby_bits = 2'b01;
        wait_lines(30);
        chk("R5 back to standby", last_w, 0);
    endtask

    // R10: low-power start abandoned
    task automatic t_lp_abort();
        ramp_lines = 8'd1;
        supply_ok  = 1'b0;
        lp_start   = 1'b1;
        wait_lines(15);
        chk("R10 reduced width reached", last_w, LPV);
        lp_start = 1'b0;
        wait_lines(15);
        chk("R10 width after drop", last_w, 0);
    endtask

    // Main sequence
    initial begin
        rst_n      = 1'b0;
        stby_bits  = 2'b00;
        mode_req   = 1'b0;
        lp_start   = 1'b0;
        supply_ok  = 1'b1;
        ramp_lines = 8'd1;
        repeat (5) step();
        rst_n = 1'b1;
        t_reset();
        t_slow_start();
        t_partial();
        t_mode_locked();
        t_flyback();
        t_slow_stop();
        t_low_power();
        t_lp_abort();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule